// File: doc/BRIEF.md
# Per-CPU Interrupt Mask and Summary

This block gathers every interrupt source that concerns one processor into a single summary word and a single request line. Four sources arrive as event strobes (serial port, interprocessor call, clock tick, console halt) and are remembered until software clears them. Four device priority levels (14 through 17) and a halt request arrive as levels and are mirrored without software control. For each device level the block also remembers which bus node raised it.

Software sees two registers through a simple read/write port: a 9-bit enable mask and a 32-bit summary. The processor request output is raised whenever any pending source is enabled by its mask bit. Transport of interrupt messages over the system bus and the processor's own priority arbitration happen outside this block.

Top module: `cpu_irq_summary`

## Requirements
- R1: After reset the mask reads 0, the summary reads 0 and `cpu_irq` is low.
- R2: A write with `reg_sel`=0 loads the mask from `reg_wdata[8:0]`; reading with `reg_sel`=0 returns the mask in bits 8:0 and zero above. Mask bit order from bit 0: serial, level 14, level 15, level 16, level 17, interprocessor call, clock, halt, console halt.
- R3: A strobe on `evt_serial`, `evt_xcall`, `evt_clock` or `evt_conhalt` sets summary bit 0, 5, 6 or 27 respectively, visible one cycle after the strobe cycle.
- R4: Writing 1 with `reg_sel`=1 to summary bit 0, 5, 6 or 27 clears it, writing 0 leaves it; a strobe in the same cycle as the clear, or a repeated strobe while the bit is pending, leaves the bit set.
- R5: Summary bits 1 to 4 (levels 14 to 17) equal `lvl_req[0..3]` from the previous cycle; software writes to them have no effect.
- R6: Summary bit 28 equals `halt_req` from the previous cycle; software writes to it have no effect.
- R7: The 5-bit node field of level k (bits 7+5k to 11+5k) takes the value of `lvl_node` slice k in the cycle that level k goes pending, keeps it while the level stays pending even if the input changes, and reads zero while the level is not pending.
- R8: `cpu_irq` is high exactly when some pending summary bit has its matching mask bit set (mask bits 7 and 8 pair with summary bits 28 and 27).
- R9: Summary bits 29 to 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_serial | input | 1 | Serial-port interrupt strobe |
| evt_xcall | input | 1 | Interprocessor call strobe |
| evt_clock | input | 1 | Clock tick strobe |
| evt_conhalt | input | 1 | Console halt strobe |
| halt_req | input | 1 | Halt request level |
| lvl_req | input | 4 | Device level requests, bit 0 = level 14 |
| lvl_node | input | 20 | Requesting node per level, 5 bits each, slice 0 = level 14 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects mask, 1 selects summary |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is the collision of a clearing write and a fresh strobe on the same bit in the same cycle, together with a node number that changes while its level is held pending. The stimulus drives both explicitly in directed steps, then runs a long phase of random strobes, levels, node numbers and writes in which such collisions recur often, with a behavioural reference compared against the outputs on every clock.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
   typedef enum logic {
      SEL_ENABLE  = 1'b0,
      SEL_PENDING = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_edge_bit.sv
module irq_edge_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (fire)
         pend <= 1'b1;
      else if (clr)
         pend <= 1'b0;
   end

   // R3: a strobe always leaves the bit pending in the next cycle
   assert_fire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> pend);
   // R4: without a clear, a pending bit stays pending
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);
endmodule

// File: rtl/irq_level_slot.sv
module irq_level_slot #(
   parameter int unsigned NODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [NODE_W-1:0] node_in,
   output logic              pend,
   output logic [NODE_W-1:0] node_q
);
   initial begin
      if (NODE_W < 1) $error("NODE_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         node_q <= '0;
      end else begin
         pend <= req;
         if (!req)
            node_q <= '0;
         else if (!pend)
            node_q <= node_in;
      end
   end

   // R5: pending mirrors the request one cycle late
   assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> pend);
   // R7: node field is frozen while the level stays asserted
   assert_node_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && req) |=> $stable(node_q));
   // R7: node field is zero whenever the level is idle
   assert_node_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |-> (node_q == '0));
endmodule

// File: rtl/cpu_irq_summary.sv
module cpu_irq_summary
   import irq_sum_pkg::*;
#(
   parameter int unsigned N_LVL  = 4,
   parameter int unsigned NODE_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    evt_serial,
   input  logic                    evt_xcall,
   input  logic                    evt_clock,
   input  logic                    evt_conhalt,
   input  logic                    halt_req,
   input  logic [N_LVL-1:0]        lvl_req,
   input  logic [N_LVL*NODE_W-1:0] lvl_node,
   input  logic                    reg_wr,
   input  logic                    reg_sel,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   output logic                    cpu_irq
);
   // summary layout
   localparam int unsigned SERIAL_BIT  = 0;
   localparam int unsigned LVL_LSB     = 1;
   localparam int unsigned XCALL_BIT   = LVL_LSB + N_LVL;
   localparam int unsigned CLOCK_BIT   = XCALL_BIT + 1;
   localparam int unsigned NODE_LSB    = CLOCK_BIT + 1;
   localparam int unsigned CONHALT_BIT = NODE_LSB + N_LVL * NODE_W;
   localparam int unsigned HALT_BIT    = CONHALT_BIT + 1;
   // mask layout
   localparam int unsigned MASK_W      = N_LVL + 5;
   localparam int unsigned N_EDGE      = 4;
   localparam int unsigned EDGE_POS [N_EDGE] = '{SERIAL_BIT, XCALL_BIT, CLOCK_BIT, CONHALT_BIT};

   initial begin
      if (HALT_BIT >= DATA_W) $error("summary layout does not fit DATA_W");
      if (MASK_W > DATA_W)    $error("mask does not fit DATA_W");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   logic wr_mask, wr_sum;
   assign wr_mask = reg_wr && (sel == SEL_ENABLE);
   assign wr_sum  = reg_wr && (sel == SEL_PENDING);

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // mask register
   logic [MASK_W-1:0] mask_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_mask)
         mask_q <= reg_wdata[MASK_W-1:0];
   end

   // event-type pending bits
   logic [N_EDGE-1:0] edge_fire, edge_clr, edge_p;
   assign edge_fire = {evt_conhalt, evt_clock, evt_xcall, evt_serial};

   for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
      assign edge_clr[e] = wr_sum && reg_wdata[EDGE_POS[e]];
      irq_edge_bit u_bit (
         .clk  (clk),
         .rst_n(rst_n),
         .fire (edge_fire[e]),
         .clr  (edge_clr[e]),
         .pend (edge_p[e])
      );
   end

   // level-type pending bits with node capture
   logic [N_LVL-1:0]  lvl_p;
   logic [NODE_W-1:0] node_q [N_LVL];

   for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
      irq_level_slot #(.NODE_W(NODE_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .req    (lvl_req[k]),
         .node_in(lvl_node[k*NODE_W +: NODE_W]),
         .pend   (lvl_p[k]),
         .node_q (node_q[k])
      );
   end

   logic halt_q;
   always_ff @(posedge clk) begin
      if (!rst_n) halt_q <= 1'b0;
      else        halt_q <= halt_req;
   end

   // summary assembly
   logic [DATA_W-1:0] sum_w;
   always_comb begin
      sum_w              = '0;
      sum_w[SERIAL_BIT]  = edge_p[0];
      sum_w[XCALL_BIT]   = edge_p[1];
      sum_w[CLOCK_BIT]   = edge_p[2];
      sum_w[CONHALT_BIT] = edge_p[3];
      sum_w[HALT_BIT]    = halt_q;
      for (int k = 0; k < N_LVL; k++) begin
         sum_w[LVL_LSB + k]                = lvl_p[k];
         sum_w[NODE_LSB + k*NODE_W +: NODE_W] = node_q[k];
      end
   end

   // pending vector in mask order
   logic [MASK_W-1:0] pend_m;
   assign pend_m = {edge_p[3], halt_q, edge_p[2], edge_p[1], lvl_p, edge_p[0]};

   assign cpu_irq = |(pend_m & mask_q);

   always_comb begin
      reg_rdata = '0;
      if (sel == SEL_PENDING) reg_rdata = sum_w;
      else                    reg_rdata[MASK_W-1:0] = mask_q;
   end

   // R2: mask write lands in the next cycle
   assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_q == $past(reg_wdata[MASK_W-1:0])));
   // R6: halt bit mirrors the halt input
   assert_halt_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (halt_q == $past(halt_req)));
   // R8: nothing enabled means no request
   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !cpu_irq);
   // R8: an enabled pending halt raises the request
   assert_irq_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[N_LVL+3] && halt_q) |-> cpu_irq);
endmodule

// File: tb/cpu_irq_summary_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_summary_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        evt_serial, evt_xcall, evt_clock, evt_conhalt, halt_req;
   logic [3:0]  lvl_req;
   logic [19:0] lvl_node;
   logic        reg_wr, reg_sel;
   logic [31:0] reg_wdata, reg_rdata;
   logic        cpu_irq;

   always #2.5 clk = ~clk;

   cpu_irq_summary dut_i (
      .clk(clk), .rst_n(rst_n),
      .evt_serial(evt_serial), .evt_xcall(evt_xcall), .evt_clock(evt_clock),
      .evt_conhalt(evt_conhalt), .halt_req(halt_req),
      .lvl_req(lvl_req), .lvl_node(lvl_node),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   string tag      = "R1";

   // behavioural reference
   logic [31:0] m_sum;
   logic [8:0]  m_mask;

   task automatic model_update();
      logic [31:0] nx;
      int pos [4];
      logic ev [4];
      pos = '{0, 5, 6, 27};
      ev  = '{evt_serial, evt_xcall, evt_clock, evt_conhalt};
      if (!rst_n) begin
         m_sum  = '0;
         m_mask = '0;
         return;
      end
      nx = m_sum;
      for (int i = 0; i < 4; i++) begin
         if (ev[i]) nx[pos[i]] = 1'b1;
         else if (reg_wr && reg_sel && reg_wdata[pos[i]]) nx[pos[i]] = 1'b0;
      end
      for (int k = 0; k < 4; k++) begin
         nx[1+k] = lvl_req[k];
         if (!lvl_req[k])      nx[7+5*k +: 5] = 5'd0;
         else if (!m_sum[1+k]) nx[7+5*k +: 5] = lvl_node[5*k +: 5];
      end
      nx[28] = halt_req;
      if (reg_wr && !reg_sel) m_mask = reg_wdata[8:0];
      m_sum = nx;
   endtask

   function automatic logic model_irq();
      int bitpos [9];
      logic r;
      bitpos = '{0, 1, 2, 3, 4, 5, 6, 28, 27};
      r = 1'b0;
      for (int i = 0; i < 9; i++)
         if (m_mask[i] && m_sum[bitpos[i]]) r = 1'b1;
      return r;
   endfunction

   task automatic compare();
      logic [31:0] exp_rd;
      exp_rd = reg_sel ? m_sum : {23'd0, m_mask};
      n_checks++;
      if (cpu_irq !== model_irq()) begin
         n_fail++;
         $display("FAIL %s cpu_irq actual=%0b expected=%0b t=%0t", tag, cpu_irq, model_irq(), $time);
      end
      n_checks++;
      if (reg_rdata !== exp_rd) begin
         n_fail++;
         $display("FAIL %s rdata sel=%0b actual=%h expected=%h t=%0t", tag, reg_sel, reg_rdata, exp_rd, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   task automatic idle_inputs();
      evt_serial = 0; evt_xcall = 0; evt_clock = 0; evt_conhalt = 0;
      reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_wr = 1; reg_sel = sel; reg_wdata = d;
      cyc();
      reg_wr = 0; reg_wdata = '0;
   endtask

   // explicit check against a fixed expectation
   task automatic expect_rd(input logic sel, input logic [31:0] exp, input string req);
      reg_sel = sel;
      #0.1;
      n_checks++;
      if (reg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s direct read sel=%0b actual=%h expected=%h", req, sel, reg_rdata, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 0; halt_req = 0; lvl_req = '0; lvl_node = '0; reg_sel = 0;
      idle_inputs();
      cyc(); cyc();
      rst_n = 1;
      // R1: reset state
      tag = "R1";
      expect_rd(0, 32'h0, "R1");
      expect_rd(1, 32'h0, "R1");
      cyc();

      // R2 and R9: mask width and reserved summary bits
      tag = "R2";
      wr(0, 32'hFFFF_FFFF);
      expect_rd(0, 32'h0000_01FF, "R2");
      wr(0, 32'h0);
      tag = "R9";
      reg_sel = 1;
      wr(1, 32'hFFFF_FFFF);
      expect_rd(1, 32'h0, "R9");

      // R3: each strobe sets its bit
      tag = "R3";
      evt_serial = 1; cyc(); evt_serial = 0;
      evt_xcall  = 1; cyc(); evt_xcall  = 0;
      evt_clock  = 1; cyc(); evt_clock  = 0;
      evt_conhalt = 1; cyc(); evt_conhalt = 0;
      expect_rd(1, 32'h0800_0061, "R3");

      // R4: write zero, partial clear, collision, refire
      tag = "R4";
      wr(1, 32'h0);
      expect_rd(1, 32'h0800_0061, "R4");
      wr(1, 32'h0000_0020);
      expect_rd(1, 32'h0800_0041, "R4");
      evt_serial = 1; wr(1, 32'h0000_0001); evt_serial = 0;
      expect_rd(1, 32'h0800_0041, "R4");
      evt_clock = 1; cyc(); cyc(); evt_clock = 0;
      expect_rd(1, 32'h0800_0041, "R4");
      wr(1, 32'h0800_0041);
      expect_rd(1, 32'h0, "R4");

      // R5 and R7: levels with node capture and hold
      tag = "R7";
      lvl_node = {5'd21, 5'd17, 5'd9, 5'd3};
      lvl_req = 4'b0101;
      cyc();
      expect_rd(1, (32'd17 << 17) | (32'd3 << 7) | 32'h0000_000A, "R7");
      lvl_node = {5'd30, 5'd30, 5'd30, 5'd30};
      cyc();
      expect_rd(1, (32'd17 << 17) | (32'd3 << 7) | 32'h0000_000A, "R7");
      tag = "R5";
      wr(1, 32'hFFFF_FFFF);
      expect_rd(1, (32'd17 << 17) | (32'd3 << 7) | 32'h0000_000A, "R5");
      lvl_req = 4'b0001;
      cyc();
      expect_rd(1, (32'd3 << 7) | 32'h0000_0002, "R7");
      lvl_req = 4'b1000;
      cyc();
      expect_rd(1, (32'd30 << 22) | 32'h0000_0010, "R5");
      lvl_req = 4'b0000;
      cyc();

      // R6: halt follows level, writes ignored
      tag = "R6";
      halt_req = 1; cyc();
      expect_rd(1, 32'h1000_0000, "R6");
      wr(1, 32'h1000_0000);
      expect_rd(1, 32'h1000_0000, "R6");
      halt_req = 0; cyc();
      expect_rd(1, 32'h0, "R6");

      // R8: one mask bit at a time against matching and other sources
      tag = "R8";
      halt_req = 1; wr(0, 32'h0000_0080);
      n_checks++;
      if (cpu_irq !== 1'b1) begin
         n_fail++;
         $display("FAIL R8 halt enabled actual=%0b expected=1", cpu_irq);
      end
      wr(0, 32'h0000_017F);
      n_checks++;
      if (cpu_irq !== 1'b0) begin
         n_fail++;
         $display("FAIL R8 halt masked actual=%0b expected=0", cpu_irq);
      end
      halt_req = 0;
      evt_conhalt = 1; cyc(); evt_conhalt = 0;
      cyc();
      wr(1, 32'h0800_0000);

      // R8: random mix compared every clock
      tag = "R8";
      for (int n = 0; n < 3000; n++) begin
         evt_serial  = ($urandom_range(0, 7) == 0);
         evt_xcall   = ($urandom_range(0, 7) == 0);
         evt_clock   = ($urandom_range(0, 7) == 0);
         evt_conhalt = ($urandom_range(0, 9) == 0);
         halt_req    = ($urandom_range(0, 5) == 0) ? ~halt_req : halt_req;
         if ($urandom_range(0, 3) == 0) lvl_req = 4'($urandom);
         lvl_node    = 20'($urandom);
         reg_sel     = 1'($urandom);
         reg_wr      = ($urandom_range(0, 3) == 0);
         reg_wdata   = $urandom;
         cyc();
      end
      idle_inputs();
      cyc();
      finish_run();
   end
endmodule